// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs integer multiplication, multiply-accumulate and division for a 64-bit integer core. It holds the two architectural result registers, HI and LO, itself. The core presents an operation code and two operands together with a one-cycle start strobe. The unit raises a one-cycle done pulse when the new HI and LO values are visible. The core can read HI and LO at any time and can load either one directly while the unit is idle.

The 32-bit operations use only the low words of the operands. They treat the low words of HI and LO together as one 64-bit accumulator, and each half they write back is sign-extended to the full register width. The 64-bit multiply keeps all 128 product bits across the register pair. Division runs one quotient bit per cycle. Multiplication finishes in one cycle after the start is accepted.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, HI and LO are zero, and busy and done are low.
- R2: Opcode 0 (signed) and opcode 1 (unsigned) multiply the low 32 bits of the two operands, sign-extended or zero-extended, into a 64-bit product. Bits 31:0 of the product go to LO and bits 63:32 go to HI, and each word is sign-extended from its bit 31 to 64 bits.
- R3: Opcodes 2 (signed) and 3 (unsigned) add the 32-bit product to the accumulator {HI[31:0], LO[31:0]}. Opcodes 4 (signed) and 5 (unsigned) subtract it. The arithmetic wraps modulo 2^64, and the result is written back split and sign-extended as in R2.
- R4: Opcode 6 (signed) and opcode 7 (unsigned) multiply the full 64-bit operands. LO receives product bits 63:0 and HI receives product bits 127:64.
- R5: Opcode 8 (signed) and opcode 9 (unsigned) divide operand A by operand B. The quotient goes to LO and the remainder to HI. Signed division truncates toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives that dividend as quotient and zero as remainder.
- R6: A divide with a zero divisor, and any opcode from 10 to 15, completes with a done pulse but leaves HI and LO unchanged.
- R7: Busy is high from the cycle after a start is accepted until the cycle done is high. A multiply raises done on the second clock edge after the start edge. A start seen while busy is ignored.
- R8: A direct load of HI (hi_we) or LO (lo_we) from wr_data takes effect only while busy is low. While busy is high it is ignored.
- R9: Done is high for exactly one cycle per accepted start, in the cycle when the new HI and LO values first appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; accepted when busy is low |
| op | input | 4 | Operation code (see R2 to R6) |
| src_a | input | XLEN | Operand A / dividend |
| src_b | input | XLEN | Operand B / divisor |
| hi_we | input | 1 | Direct load of HI |
| lo_we | input | 1 | Direct load of LO |
| wr_data | input | XLEN | Data for direct loads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | XLEN | HI register |
| lo | output | XLEN | LO register |

## Verification
The bench targets signed division with mixed operand signs. A design that gets the sign fix-up wrong returns a floored quotient or a remainder of the wrong sign. The most-negative dividend divided by -1 exposes any design that saturates or traps instead of wrapping. Multiply-add and multiply-subtract chains are run with carries across bit 31 and wrap past 2^64. These catch a design that accumulates the full 64-bit registers instead of the split low words, or that skips the sign extension. A zero divisor, unused opcodes, and a start strobe and direct loads issued while busy all check for state that was wrongly overwritten, which would show up as a changed HI or LO value.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic [3:0] {
      OP_MUL   = 4'd0,
      OP_MULU  = 4'd1,
      OP_MADD  = 4'd2,
      OP_MADDU = 4'd3,
      OP_MSUB  = 4'd4,
      OP_MSUBU = 4'd5,
      OP_DMUL  = 4'd6,
      OP_DMULU = 4'd7,
      OP_DDIV  = 4'd8,
      OP_DDIVU = 4'd9
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL  = 2'd1,
      ST_DIV  = 2'd2,
      ST_NOP  = 2'd3
   } mdu_state_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic              is_signed,
   input  logic              half,
   output logic [2*XLEN-1:0] prod
);
   localparam int HALF = XLEN / 2;
   localparam int PW   = 2 * XLEN;

   logic [PW-1:0] ext_a, ext_b;

   always_comb begin
      if (half) begin
         ext_a = {{(PW-HALF){is_signed & a[HALF-1]}}, a[HALF-1:0]};
         ext_b = {{(PW-HALF){is_signed & b[HALF-1]}}, b[HALF-1:0]};
      end else begin
         ext_a = {{XLEN{is_signed & a[XLEN-1]}}, a};
         ext_b = {{XLEN{is_signed & b[XLEN-1]}}, b};
      end
      prod = ext_a * ext_b;
   end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [XLEN-1:0] dividend,
   input  logic [XLEN-1:0] divisor,
   input  logic            is_signed,
   output logic            fin,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   localparam int CW = $clog2(XLEN + 1);

   logic [CW-1:0]   cnt;
   logic            run;
   logic [XLEN-1:0] r_mag, q_mag, d_mag;
   logic            neg_q, neg_r;
   logic [XLEN:0]   r_sh, diff;

   assign r_sh = {r_mag, q_mag[XLEN-1]};
   assign diff = r_sh - {1'b0, d_mag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
         r_mag <= '0;
         q_mag <= '0;
         d_mag <= '0;
         neg_q <= 1'b0;
         neg_r <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            neg_q <= is_signed & (dividend[XLEN-1] ^ divisor[XLEN-1]);
            neg_r <= is_signed & dividend[XLEN-1];
            q_mag <= (is_signed && dividend[XLEN-1]) ? -dividend : dividend;
            d_mag <= (is_signed && divisor[XLEN-1]) ? -divisor : divisor;
            r_mag <= '0;
            cnt   <= CW'(XLEN);
            run   <= 1'b1;
         end else if (run) begin
            if (!diff[XLEN]) begin
               r_mag <= diff[XLEN-1:0];
               q_mag <= {q_mag[XLEN-2:0], 1'b1};
            end else begin
               r_mag <= r_sh[XLEN-1:0];
               q_mag <= {q_mag[XLEN-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quo = neg_q ? -q_mag : q_mag;
   assign rem = neg_r ? -r_mag : r_mag;

   // R5: the magnitude of the remainder stays below the divisor magnitude
   p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (r_mag < d_mag));

   // R7: a running division never sees a fresh load
   p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !load);
endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
   import mdu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic            hi_we,
   input  logic            lo_we,
   input  logic [XLEN-1:0] wr_data,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] hi,
   output logic [XLEN-1:0] lo
);
   localparam int HALF = XLEN / 2;

   generate
      if ((XLEN % 2) != 0 || XLEN < 8) begin : g_bad_xlen
         $error("hilo_mdu: XLEN must be even and at least 8");
      end
   endgenerate

   mdu_state_e      state;
   mdu_op_e         op_q;
   logic [XLEN-1:0] a_q, b_q;

   logic accept, in_div, in_valid, div_load, div_fin, fin_now;
   logic q_half, q_signed, q_add, q_sub;
   logic [2*XLEN-1:0] prod;
   logic [XLEN-1:0]   acc, mac, mul_hi, mul_lo, div_q, div_r;

   assign busy     = (state != ST_IDLE);
   assign accept   = start && !busy;
   assign in_valid = (op <= 4'(OP_DDIVU));
   assign in_div   = (op == 4'(OP_DDIV)) || (op == 4'(OP_DDIVU));
   assign div_load = accept && in_div && (src_b != '0);

   assign q_half   = (op_q <= OP_MSUBU);
   assign q_signed = (op_q == OP_MUL) || (op_q == OP_MADD) ||
                     (op_q == OP_MSUB) || (op_q == OP_DMUL);
   assign q_add    = (op_q == OP_MADD) || (op_q == OP_MADDU);
   assign q_sub    = (op_q == OP_MSUB) || (op_q == OP_MSUBU);

   mdu_mul #(.XLEN(XLEN)) u_mul (
      .a(a_q), .b(b_q), .is_signed(q_signed), .half(q_half), .prod(prod)
   );

   mdu_div #(.XLEN(XLEN)) u_div (
      .clk(clk), .rst_n(rst_n), .load(div_load),
      .dividend(src_a), .divisor(src_b), .is_signed(op == 4'(OP_DDIV)),
      .fin(div_fin), .quo(div_q), .rem(div_r)
   );

   always_comb begin
      acc = {hi[HALF-1:0], lo[HALF-1:0]};
      if (q_add)      mac = acc + prod[XLEN-1:0];
      else if (q_sub) mac = acc - prod[XLEN-1:0];
      else            mac = prod[XLEN-1:0];
      if (q_half) begin
         mul_hi = {{HALF{mac[XLEN-1]}}, mac[XLEN-1:HALF]};
         mul_lo = {{HALF{mac[HALF-1]}}, mac[HALF-1:0]};
      end else begin
         mul_hi = prod[2*XLEN-1:XLEN];
         mul_lo = prod[XLEN-1:0];
      end
   end

   assign fin_now = (state == ST_MUL) || (state == ST_NOP) ||
                    ((state == ST_DIV) && div_fin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_q  <= OP_MUL;
         a_q   <= '0;
         b_q   <= '0;
         hi    <= '0;
         lo    <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (hi_we) hi <= wr_data;
               if (lo_we) lo <= wr_data;
               if (accept) begin
                  op_q <= mdu_op_e'(op);
                  a_q  <= src_a;
                  b_q  <= src_b;
                  if (!in_valid || (in_div && src_b == '0)) state <= ST_NOP;
                  else if (in_div)                          state <= ST_DIV;
                  else                                      state <= ST_MUL;
               end
            end
            ST_MUL: begin
               hi    <= mul_hi;
               lo    <= mul_lo;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            ST_DIV: begin
               if (div_fin) begin
                  hi    <= div_r;
                  lo    <= div_q;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // R7: an accepted start makes the unit busy on the next cycle
   p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   // R9: done only follows a busy cycle and never overlaps busy
   p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R6: a zero-divisor divide leaves both registers alone
   p_div0_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && in_div && src_b == '0 && !hi_we && !lo_we)
      |=> ($stable(hi) && $stable(lo)) ##1 ($stable(hi) && $stable(lo)));

   // R8: direct loads while busy do not reach HI or LO
   p_hi_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin_now && hi_we) |=> $stable(hi));
   p_lo_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin_now && lo_we) |=> $stable(lo));

   // R2: a 32-bit form always leaves both registers sign-extended
   p_half_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && q_half) |->
      (hi[XLEN-1:HALF] == {HALF{hi[HALF-1]}}) &&
      (lo[XLEN-1:HALF] == {HALF{lo[HALF-1]}}));
endmodule

// File: tb/hilo_mdu_test.sv
`timescale 1ns/1ps
module hilo_mdu_test;
   localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op = '0;
   logic [63:0] src_a = '0, src_b = '0, wr_data = '0;
   logic        hi_we = 1'b0, lo_we = 1'b0;
   logic        busy, done;
   logic [63:0] hi, lo;

   int total = 0;
   int bad = 0;
   logic [63:0] mhi = '0, mlo = '0;

   always #2.5 clk = ~clk;

   hilo_mdu #(.XLEN(64)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .hi_we(hi_we), .lo_we(lo_we),
      .wr_data(wr_data), .busy(busy), .done(done), .hi(hi), .lo(lo)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] sx32(logic [31:0] w);
      return {{32{w[31]}}, w};
   endfunction

   // returns {write, hi, lo}
   function automatic logic [128:0] model(logic [3:0] c, logic [63:0] a,
                                          logic [63:0] b, logic [63:0] h,
                                          logic [63:0] l);
      logic [63:0] ea, eb, s, acc, q, r;
      logic [127:0] p;
      logic sg;
      if (c <= 4'd5) begin
         sg  = (c == 0) || (c == 2) || (c == 4);
         ea  = sg ? sx32(a[31:0]) : {32'b0, a[31:0]};
         eb  = sg ? sx32(b[31:0]) : {32'b0, b[31:0]};
         s   = ea * eb;
         acc = {h[31:0], l[31:0]};
         if (c == 2 || c == 3) s = acc + s;
         if (c == 4 || c == 5) s = acc - s;
         return {1'b1, sx32(s[63:32]), sx32(s[31:0])};
      end else if (c == 6 || c == 7) begin
         sg = (c == 6);
         p  = {{64{sg & a[63]}}, a} * {{64{sg & b[63]}}, b};
         return {1'b1, p[127:64], p[63:0]};
      end else if (c == 8 || c == 9) begin
         if (b == 0) return {1'b0, h, l};
         if (c == 9) begin
            q = a / b; r = a % b;
         end else if (a == MINV && b == '1) begin
            q = MINV; r = '0;
         end else begin
            q = 64'($signed(a) / $signed(b));
            r = 64'($signed(a) % $signed(b));
         end
         return {1'b1, r, q};
      end
      return {1'b0, h, l};
   endfunction

   function automatic string tag(logic [3:0] c, logic [63:0] b);
      if (c <= 1) return "R2";
      if (c <= 5) return "R3";
      if (c <= 7) return "R4";
      if (c <= 9 && b != 0) return "R5";
      return "R6";
   endfunction

   task automatic run_op(logic [3:0] c, logic [63:0] a, logic [63:0] b, bit intrude);
      logic [128:0] e;
      int n;
      e = model(c, a, b, mhi, mlo);
      @(negedge clk);
      start = 1'b1; op = c; src_a = a; src_b = b;
      @(negedge clk);
      start = 1'b0;
      chk("R7 busy after start", {63'b0, busy & ~done}, 64'd1);
      if (intrude) begin
         start = 1'b1; op = 4'd0; src_a = ~a; src_b = 64'd3;
         hi_we = 1'b1; lo_we = 1'b1; wr_data = 64'h5A5A_1234_DEAD_BEEF;
         @(negedge clk);
         start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
      end
      n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R9 done seen", {63'b0, done}, 64'd1);
      chk("R7 idle at done", {63'b0, busy}, 64'd0);
      if (e[128]) begin
         mhi = e[127:64]; mlo = e[63:0];
      end
      chk({tag(c, b), " hi"}, hi, mhi);
      chk({tag(c, b), " lo"}, lo, mlo);
   endtask

   task automatic direct(bit wh, bit wl, logic [63:0] d);
      @(negedge clk);
      hi_we = wh; lo_we = wl; wr_data = d;
      @(negedge clk);
      hi_we = 1'b0; lo_we = 1'b0;
      if (wh) mhi = d;
      if (wl) mlo = d;
      chk("R8 direct hi", hi, mhi);
      chk("R8 direct lo", lo, mlo);
   endtask

   initial begin
      #(5.0 * 190000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [3:0]  c;
      logic [63:0] a, b;
      void'($urandom(32'd20240611));
      #12 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hi", hi, 64'd0);
      chk("R1 lo", lo, 64'd0);
      chk("R1 busy/done", {62'b0, busy, done}, 64'd0);

      // R2 directed
      run_op(4'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 1'b0);
      run_op(4'd1, 64'h1234_5678_FFFF_FFFF, 64'hFFFF_FFFF, 1'b0);
      // R3 chain with wrap
      direct(1'b1, 1'b1, 64'h0000_0000_7FFF_FFFF);
      run_op(4'd3, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0);
      run_op(4'd2, 64'h8000_0000, 64'h8000_0000, 1'b0);
      run_op(4'd5, 64'd1, 64'd1, 1'b0);
      run_op(4'd4, 64'hFFFF_FFFF, 64'd7, 1'b0);
      // R4
      run_op(4'd6, '1, '1, 1'b0);
      run_op(4'd7, '1, '1, 1'b0);
      run_op(4'd6, MINV, MINV, 1'b0);
      // R5
      run_op(4'd8, -64'sd7, 64'd2, 1'b0);
      run_op(4'd8, 64'd7, -64'sd2, 1'b0);
      run_op(4'd8, MINV, '1, 1'b0);
      run_op(4'd9, '1, 64'd10, 1'b0);
      // R7: intruding start and loads while a divide runs
      run_op(4'd8, 64'd1000, 64'd7, 1'b1);
      // R6 with R8 loads while busy
      run_op(4'd8, 64'd55, 64'd0, 1'b1);
      run_op(4'd9, 64'd55, 64'd0, 1'b0);
      run_op(4'd12, 64'd3, 64'd4, 1'b1);
      run_op(4'd1, 64'd9, 64'd9, 1'b1);
      direct(1'b0, 1'b1, 64'hCAFE);
      direct(1'b1, 1'b0, 64'hBEEF);

      for (int i = 0; i < 400; i++) begin
         c = 4'($urandom % 16);
         if (c > 4'd11) c = 4'($urandom % 10);
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         case ($urandom % 8)
            0: b = '0;
            1: b = 64'($urandom % 5) - 64'd2;
            2: a = MINV;
            default: ;
         endcase
         run_op(c, a, b, ($urandom % 6) == 0);
         @(negedge clk);
         chk("R9 single pulse", {63'b0, done}, 64'd0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule